// File: doc/BRIEF.md
# Event Routing Table

This block maps interrupt sources to event queues. It keeps one 64-bit routing descriptor for each source and uses the source number itself as the table index, with no offset. Each descriptor names a destination queue block, a queue index and the event data that the queue will receive. Two further bits decide whether a trigger from that source goes through.

A configuration port acts on one entry per command. It can read a descriptor, write a whole descriptor, allocate an entry (set its valid bit) or free it (clear its valid bit). Every command gets a response one cycle later with a success flag and the entry's resulting value. A trigger port accepts a source number. When that entry is valid and not masked, the block emits a one-cycle notification that carries the three routing fields.

A sweep request runs a masking pass over the whole table, one entry per cycle. The pass sets the masked bit of every valid entry and does not change invalid entries. While the pass runs, a busy flag is high and all commands and triggers are refused.

Top module: `evt_route_table`

## Requirements
- R1: After power-up reset every descriptor reads back as all zeros (invalid, unmasked), `busy_o` is low and no notification is pending.
- R2: Descriptor bits are numbered from the most significant end, so bit n of the descriptor is bit 63-n of the 64-bit word. Valid is word bit 63, queue block is word bits 59:56, queue index is word bits 55:32, masked is word bit 31 and event data is word bits 30:0. A written word reads back unchanged.
- R3: A trigger on a valid, unmasked entry raises `ntf_valid_o` for exactly one cycle, on the cycle after the trigger, with block, index and data taken from the entry's fields.
- R4: A trigger on an entry whose valid bit is clear produces no notification.
- R5: A trigger on an entry that is valid and masked produces no notification.
- R6: A command or trigger whose source number is greater than or equal to NUM_SRC is refused. A command answers `cfg_ok_o`=0, a trigger answers `trig_err_o`=1, and no descriptor changes.
- R7: Command encoding on `cfg_op_i` is 0=read, 1=write, 2=allocate, 3=free. Allocate sets only the valid bit and free clears only the valid bit. Each reports `cfg_ok_o`=1 and returns the resulting word on `cfg_rdata_o` one cycle after the request.
- R8: A sweep sets the masked bit of every valid entry and leaves every invalid entry bit-for-bit unchanged.
- R9: `busy_o` rises the cycle after a sweep request and stays high for exactly NUM_SRC cycles. While it is high, commands answer `cfg_ok_o`=0 and triggers answer `trig_err_o`=1 with no notification.
- R10: When a write and a trigger address the same entry in the same cycle, the notification uses the descriptor value from before the write.
- R11: Entry k is routed for source number k, including entries 0 and NUM_SRC-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset, clears the whole table |
| sweep_req_i | input | 1 | Starts a masking sweep (ignored while busy) |
| busy_o | output | 1 | Sweep in progress |
| cfg_req_i | input | 1 | Configuration command strobe |
| cfg_op_i | input | 2 | Command: 0 read, 1 write, 2 allocate, 3 free |
| cfg_src_i | input | SRC_W | Source number addressed by the command |
| cfg_wdata_i | input | 64 | Descriptor for a write command |
| cfg_done_o | output | 1 | Command response strobe, one cycle after request |
| cfg_ok_o | output | 1 | Command accepted |
| cfg_rdata_o | output | 64 | Resulting descriptor value (zero when refused) |
| trig_req_i | input | 1 | Trigger strobe |
| trig_src_i | input | SRC_W | Source number of the trigger |
| trig_err_o | output | 1 | Trigger refused (out of range or busy) |
| ntf_valid_o | output | 1 | Notification pulse |
| ntf_block_o | output | 4 | Destination queue block |
| ntf_index_o | output | 24 | Destination queue index |
| ntf_data_o | output | 31 | Event data |

## Verification
Assertions check the following on every cycle: a refused command or trigger never yields success or a notification, every notification follows an accepted trigger on a live entry, the sweep pointer advances one step per cycle and the pass ends on time, and each sweep step masks a valid entry and leaves an invalid one untouched. Some behaviours can only be shown by the bench's scenarios. These are exact field placement, the allocate and free read-modify-write results, the old value used when a write and a trigger meet on one entry, and the table contents seen through read-back after a full sweep.

// File: rtl/evt_route_pkg.sv
package evt_route_pkg;

    localparam int DESC_W  = 64;
    localparam int BLK_W   = 4;
    localparam int QIDX_W  = 24;
    localparam int EDATA_W = 31;

    // Descriptor numbering is MSB-first: descriptor bit n sits at word bit 63-n.
    localparam int VLD_BIT  = DESC_W - 1 - 0;   // descriptor bit 0
    localparam int BLK_HI   = DESC_W - 1 - 4;   // descriptor bits 4..7
    localparam int BLK_LO   = DESC_W - 1 - 7;
    localparam int QIDX_HI  = DESC_W - 1 - 8;   // descriptor bits 8..31
    localparam int QIDX_LO  = DESC_W - 1 - 31;
    localparam int MSK_BIT  = DESC_W - 1 - 32;  // descriptor bit 32
    localparam int EDATA_HI = DESC_W - 1 - 33;  // descriptor bits 33..63
    localparam int EDATA_LO = DESC_W - 1 - 63;

    typedef enum logic [1:0] {
        CFG_READ  = 2'd0,
        CFG_WRITE = 2'd1,
        CFG_ALLOC = 2'd2,
        CFG_FREE  = 2'd3
    } cfg_op_e;

    typedef struct packed {
        logic               vld;
        logic [BLK_W-1:0]   blk;
        logic [QIDX_W-1:0]  qidx;
        logic [EDATA_W-1:0] edata;
    } notify_t;

    function automatic logic desc_live(input logic [DESC_W-1:0] d);
        return d[VLD_BIT] && !d[MSK_BIT];
    endfunction

    function automatic notify_t desc_route(input logic [DESC_W-1:0] d);
        notify_t n;
        n.vld   = 1'b1;
        n.blk   = d[BLK_HI:BLK_LO];
        n.qidx  = d[QIDX_HI:QIDX_LO];
        n.edata = d[EDATA_HI:EDATA_LO];
        return n;
    endfunction

endpackage

// File: rtl/evt_sweep_ctrl.sv
module evt_sweep_ctrl #(
    parameter int NUM_SRC = 32,
    parameter int IDX_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic [IDX_W-1:0] ptr_o
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] ptr;
    } sweep_st_t;

    sweep_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.ptr  = '0;
            end
        end else if (st_q.ptr == LAST) begin
            st_d.busy = 1'b0;
            st_d.ptr  = '0;
        end else begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign ptr_o  = st_q.ptr;

    AST_SWEEP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ptr_o != LAST) |=> (busy_o && ptr_o == $past(ptr_o) + 1'b1)); // R9
    AST_SWEEP_END: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ptr_o == LAST) |=> !busy_o); // R9
    AST_SWEEP_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (ptr_o == '0)); // R9

endmodule

// File: rtl/evt_desc_store.sv
module evt_desc_store
    import evt_route_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int IDX_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [DESC_W-1:0] wr_data_i,
    input  logic              swp_en_i,
    input  logic [IDX_W-1:0]  swp_idx_i,
    input  logic [IDX_W-1:0]  ra_idx_i,
    output logic [DESC_W-1:0] ra_data_o,
    input  logic [IDX_W-1:0]  rb_idx_i,
    output logic [DESC_W-1:0] rb_data_o
);

    logic [DESC_W-1:0] mem_d [NUM_SRC];
    logic [DESC_W-1:0] mem_q [NUM_SRC];

    // Per-entry next value: the sweep owns the table while active,
    // configuration writes are refused upstream during that time.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_entry
        always_comb begin
            mem_d[g] = mem_q[g];
            if (swp_en_i && swp_idx_i == IDX_W'(g)) begin
                if (mem_q[g][VLD_BIT]) begin
                    mem_d[g][MSK_BIT] = 1'b1;
                end
            end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
                mem_d[g] = wr_data_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else begin
                mem_q[g] <= mem_d[g];
            end
        end
    end

    assign ra_data_o = mem_q[ra_idx_i];
    assign rb_data_o = mem_q[rb_idx_i];

    AST_SWEEP_MASKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (swp_en_i && mem_q[swp_idx_i][VLD_BIT])
        |=> (mem_q[$past(swp_idx_i)][MSK_BIT] && mem_q[$past(swp_idx_i)][VLD_BIT])); // R8
    AST_SWEEP_KEEPS_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (swp_en_i && !mem_q[swp_idx_i][VLD_BIT])
        |=> (mem_q[$past(swp_idx_i)] == $past(mem_q[swp_idx_i]))); // R8
    AST_NO_WRITE_IN_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        swp_en_i |-> !wr_en_i); // R9

endmodule

// File: rtl/evt_notify_unit.sv
module evt_notify_unit
    import evt_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic [DESC_W-1:0] desc_i,
    output notify_t           ntf_o
);

    notify_t ntf_d, ntf_q;

    always_comb begin
        ntf_d = '0;
        if (fire_i && desc_live(desc_i)) begin
            ntf_d = desc_route(desc_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ntf_q <= '0;
        end else begin
            ntf_q <= ntf_d;
        end
    end

    assign ntf_o = ntf_q;

    AST_NTF_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_q.vld |-> ($past(fire_i) && $past(desc_i[VLD_BIT]) && !$past(desc_i[MSK_BIT]))); // R4 R5
    AST_NTF_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_q.vld |-> (ntf_q.blk == $past(desc_i[BLK_HI:BLK_LO])
                       && ntf_q.edata == $past(desc_i[EDATA_HI:EDATA_LO]))); // R3
    AST_NTF_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !ntf_q.vld |-> (ntf_q.blk == '0 && ntf_q.qidx == '0 && ntf_q.edata == '0)); // R3

endmodule

// File: rtl/evt_route_table.sv
module evt_route_table
    import evt_route_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int SRC_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sweep_req_i,
    output logic              busy_o,
    input  logic              cfg_req_i,
    input  logic [1:0]        cfg_op_i,
    input  logic [SRC_W-1:0]  cfg_src_i,
    input  logic [63:0]       cfg_wdata_i,
    output logic              cfg_done_o,
    output logic              cfg_ok_o,
    output logic [63:0]       cfg_rdata_o,
    input  logic              trig_req_i,
    input  logic [SRC_W-1:0]  trig_src_i,
    output logic              trig_err_o,
    output logic              ntf_valid_o,
    output logic [3:0]        ntf_block_o,
    output logic [23:0]       ntf_index_o,
    output logic [30:0]       ntf_data_o
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [SRC_W:0] SRC_LIM = (SRC_W + 1)'(NUM_SRC);

    typedef struct packed {
        logic              done;
        logic              ok;
        logic [DESC_W-1:0] rdata;
        logic              terr;
    } resp_t;

    resp_t rsp_d, rsp_q;

    logic              busy;
    logic [IDX_W-1:0]  swp_ptr;
    logic [IDX_W-1:0]  cfg_idx, trig_idx;
    logic              cfg_in_range, trig_in_range;
    logic              cfg_acc, trig_fire;
    logic [DESC_W-1:0] cfg_old, cfg_new, trig_desc;
    logic              wr_en;
    notify_t           ntf;

    assign cfg_in_range  = {1'b0, cfg_src_i}  < SRC_LIM;
    assign trig_in_range = {1'b0, trig_src_i} < SRC_LIM;
    assign cfg_idx       = IDX_W'(cfg_src_i);
    assign trig_idx      = IDX_W'(trig_src_i);
    assign cfg_acc       = cfg_req_i  && cfg_in_range  && !busy;
    assign trig_fire     = trig_req_i && trig_in_range && !busy;

    always_comb begin
        cfg_new = cfg_old;
        unique case (cfg_op_e'(cfg_op_i))
            CFG_READ:  cfg_new = cfg_old;
            CFG_WRITE: cfg_new = cfg_wdata_i;
            CFG_ALLOC: cfg_new[VLD_BIT] = 1'b1;
            CFG_FREE:  cfg_new[VLD_BIT] = 1'b0;
            default:   cfg_new = cfg_old;
        endcase
    end

    assign wr_en = cfg_acc && (cfg_op_e'(cfg_op_i) != CFG_READ);

    always_comb begin
        rsp_d       = '0;
        rsp_d.done  = cfg_req_i;
        rsp_d.ok    = cfg_acc;
        rsp_d.rdata = cfg_acc ? cfg_new : '0;
        rsp_d.terr  = trig_req_i && !trig_fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    evt_sweep_ctrl #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_sweep (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (sweep_req_i),
        .busy_o  (busy),
        .ptr_o   (swp_ptr)
    );

    evt_desc_store #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (cfg_idx),
        .wr_data_i (cfg_new),
        .swp_en_i  (busy),
        .swp_idx_i (swp_ptr),
        .ra_idx_i  (cfg_idx),
        .ra_data_o (cfg_old),
        .rb_idx_i  (trig_idx),
        .rb_data_o (trig_desc)
    );

    evt_notify_unit u_notify (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (trig_fire),
        .desc_i (trig_desc),
        .ntf_o  (ntf)
    );

    assign busy_o      = busy;
    assign cfg_done_o  = rsp_q.done;
    assign cfg_ok_o    = rsp_q.ok;
    assign cfg_rdata_o = rsp_q.rdata;
    assign trig_err_o  = rsp_q.terr;
    assign ntf_valid_o = ntf.vld;
    assign ntf_block_o = ntf.blk;
    assign ntf_index_o = ntf.qidx;
    assign ntf_data_o  = ntf.edata;

    AST_CFG_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req_i && (busy_o || !cfg_in_range)) |=> (cfg_done_o && !cfg_ok_o && cfg_rdata_o == '0)); // R6
    AST_TRIG_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_req_i && (busy_o || !trig_in_range)) |=> (trig_err_o && !ntf_valid_o)); // R9
    AST_NTF_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_valid_o |-> ($past(trig_req_i) && !$past(busy_o))); // R3
    AST_ALLOC_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_acc && cfg_op_e'(cfg_op_i) == CFG_ALLOC) |=> (cfg_ok_o && cfg_rdata_o[VLD_BIT])); // R7
    AST_FREE_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_acc && cfg_op_e'(cfg_op_i) == CFG_FREE) |=> (cfg_ok_o && !cfg_rdata_o[VLD_BIT])); // R7
    AST_BUSY_BLOCKS_SWEEP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(sweep_req_i)); // R9

endmodule

// File: tb/tb_evt_route_table.sv
module tb_evt_route_table;

    localparam int NUM_SRC = 32;
    localparam int SRC_W   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sweep_req_i = 1'b0;
    logic              busy_o;
    logic              cfg_req_i = 1'b0;
    logic [1:0]        cfg_op_i = 2'd0;
    logic [SRC_W-1:0]  cfg_src_i = '0;
    logic [63:0]       cfg_wdata_i = '0;
    logic              cfg_done_o, cfg_ok_o;
    logic [63:0]       cfg_rdata_o;
    logic              trig_req_i = 1'b0;
    logic [SRC_W-1:0]  trig_src_i = '0;
    logic              trig_err_o, ntf_valid_o;
    logic [3:0]        ntf_block_o;
    logic [23:0]       ntf_index_o;
    logic [30:0]       ntf_data_o;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    // last sampled responses
    logic        r_done, r_ok, r_terr, r_nv;
    logic [63:0] r_rdata;
    logic [3:0]  r_blk;
    logic [23:0] r_idx;
    logic [30:0] r_dat;

    evt_route_table #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) dut (
        .clk(clk), .rst_n(rst_n), .sweep_req_i(sweep_req_i), .busy_o(busy_o),
        .cfg_req_i(cfg_req_i), .cfg_op_i(cfg_op_i), .cfg_src_i(cfg_src_i),
        .cfg_wdata_i(cfg_wdata_i), .cfg_done_o(cfg_done_o), .cfg_ok_o(cfg_ok_o),
        .cfg_rdata_o(cfg_rdata_o), .trig_req_i(trig_req_i), .trig_src_i(trig_src_i),
        .trig_err_o(trig_err_o), .ntf_valid_o(ntf_valid_o), .ntf_block_o(ntf_block_o),
        .ntf_index_o(ntf_index_o), .ntf_data_o(ntf_data_o)
    );

    always #4 clk = ~clk;   // 8 ns period

    function automatic logic [63:0] mk(input logic v, input logic [3:0] b,
                                       input logic [23:0] q, input logic m,
                                       input logic [30:0] d);
        return {v, 3'b000, b, q, m, d};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic sample();
        r_done = cfg_done_o; r_ok = cfg_ok_o; r_rdata = cfg_rdata_o;
        r_terr = trig_err_o; r_nv = ntf_valid_o;
        r_blk = ntf_block_o; r_idx = ntf_index_o; r_dat = ntf_data_o;
    endtask

    // one cycle with optional command and trigger, sampled on the next negedge
    task automatic cycle(input logic c, input logic [1:0] op, input int src,
                         input logic [63:0] wd, input logic t, input int tsrc);
        @(negedge clk);
        cfg_req_i = c; cfg_op_i = op; cfg_src_i = SRC_W'(src); cfg_wdata_i = wd;
        trig_req_i = t; trig_src_i = SRC_W'(tsrc);
        @(negedge clk);
        cfg_req_i = 1'b0; trig_req_i = 1'b0;
        sample();
    endtask

    task automatic cmd(input logic [1:0] op, input int src, input logic [63:0] wd);
        cycle(1'b1, op, src, wd, 1'b0, 0);
    endtask

    task automatic trig(input int src);
        cycle(1'b0, 2'd0, 0, '0, 1'b1, src);
    endtask

    task automatic t_reset();
        chk("R1", "busy after reset", 64'(busy_o), 64'd0);
        chk("R1", "no notification after reset", 64'(ntf_valid_o), 64'd0);
        cmd(2'd0, 3, '0);
        chk("R1", "read ok", 64'(r_ok), 64'd1);
        chk("R1", "entry 3 zero", r_rdata, 64'd0);
        cmd(2'd0, NUM_SRC - 1, '0);
        chk("R1", "last entry zero", r_rdata, 64'd0);
    endtask

    task automatic t_write_route();
        logic [63:0] w;
        w = mk(1'b1, 4'hA, 24'h123456, 1'b0, 31'h1234_5678);
        cmd(2'd1, 5, w);
        chk("R2", "write ok", 64'(r_ok), 64'd1);
        cmd(2'd0, 5, '0);
        chk("R2", "readback", r_rdata, w);
        trig(5);
        chk("R3", "ntf valid", 64'(r_nv), 64'd1);
        chk("R3", "ntf block", 64'(r_blk), 64'hA);
        chk("R3", "ntf index", 64'(r_idx), 64'h123456);
        chk("R3", "ntf data", 64'(r_dat), 64'h1234_5678);
        chk("R3", "trig err", 64'(r_terr), 64'd0);
        @(negedge clk);
        chk("R3", "pulse one cycle", 64'(ntf_valid_o), 64'd0);
    endtask

    task automatic t_invalid();
        cmd(2'd1, 7, mk(1'b0, 4'h3, 24'h00_0777, 1'b0, 31'h7));
        trig(7);
        chk("R4", "invalid entry no ntf", 64'(r_nv), 64'd0);
        chk("R4", "invalid entry not an error", 64'(r_terr), 64'd0);
    endtask

    task automatic t_masked();
        cmd(2'd1, 8, mk(1'b1, 4'h5, 24'h00_0888, 1'b1, 31'h8));
        trig(8);
        chk("R5", "masked entry no ntf", 64'(r_nv), 64'd0);
    endtask

    task automatic t_alloc_free();
        logic [63:0] w;
        w = mk(1'b0, 4'h9, 24'hABCDEF, 1'b0, 31'h4321_0FED);
        cmd(2'd1, 9, w);
        cmd(2'd2, 9, '0);
        chk("R7", "alloc ok", 64'(r_ok), 64'd1);
        chk("R7", "alloc result", r_rdata, w | (64'd1 << 63));
        trig(9);
        chk("R7", "ntf after alloc", 64'(r_nv), 64'd1);
        chk("R7", "index after alloc", 64'(r_idx), 64'hABCDEF);
        cmd(2'd3, 9, '0);
        chk("R7", "free ok", 64'(r_ok), 64'd1);
        chk("R7", "free result", r_rdata, w);
        trig(9);
        chk("R7", "no ntf after free", 64'(r_nv), 64'd0);
    endtask

    task automatic t_out_of_range();
        cmd(2'd1, NUM_SRC, mk(1'b1, 4'hF, 24'hFFFFFF, 1'b0, 31'h1));
        chk("R6", "write oor refused", 64'(r_ok), 64'd0);
        chk("R6", "write oor done", 64'(r_done), 64'd1);
        cmd(2'd2, NUM_SRC + 9, '0);
        chk("R6", "alloc oor refused", 64'(r_ok), 64'd0);
        cmd(2'd0, 0, '0);
        chk("R6", "entry 0 untouched", r_rdata, 64'd0);
        cmd(2'd0, 9, '0);
        chk("R6", "entry 9 still free", 64'(r_rdata[63]), 64'd0);
        trig(200);
        chk("R6", "trigger oor error", 64'(r_terr), 64'd1);
        chk("R6", "trigger oor no ntf", 64'(r_nv), 64'd0);
    endtask

    task automatic t_edges();
        cmd(2'd1, 0, mk(1'b1, 4'h1, 24'h000001, 1'b0, 31'h11));
        cmd(2'd1, NUM_SRC - 1, mk(1'b1, 4'h2, 24'h000002, 1'b0, 31'h22));
        trig(0);
        chk("R11", "entry 0 data", 64'(r_dat), 64'h11);
        trig(NUM_SRC - 1);
        chk("R11", "last entry data", 64'(r_dat), 64'h22);
        chk("R11", "last entry block", 64'(r_blk), 64'h2);
    endtask

    task automatic t_collide();
        cmd(2'd1, 10, mk(1'b1, 4'h6, 24'h0000AA, 1'b0, 31'hAA));
        cycle(1'b1, 2'd1, 10, mk(1'b1, 4'h7, 24'h0000BB, 1'b0, 31'hBB), 1'b1, 10);
        chk("R10", "same-cycle ntf", 64'(r_nv), 64'd1);
        chk("R10", "same-cycle uses old data", 64'(r_dat), 64'hAA);
        trig(10);
        chk("R10", "next trigger uses new data", 64'(r_dat), 64'hBB);
    endtask

    task automatic t_sweep();
        int n = 0;
        int guard = 0;
        @(negedge clk);
        sweep_req_i = 1'b1;
        @(negedge clk);
        sweep_req_i = 1'b0;
        chk("R9", "busy raised", 64'(busy_o), 64'd1);
        if (busy_o) n++;
        cfg_req_i = 1'b1; cfg_op_i = 2'd1; cfg_src_i = SRC_W'(7);
        cfg_wdata_i = mk(1'b1, 4'h0, 24'h0, 1'b0, 31'h0);
        trig_req_i = 1'b1; trig_src_i = SRC_W'(5);
        @(negedge clk);
        cfg_req_i = 1'b0; trig_req_i = 1'b0;
        sample();
        if (busy_o) n++;
        chk("R9", "command refused while busy", 64'(r_ok), 64'd0);
        chk("R9", "trigger refused while busy", 64'(r_terr), 64'd1);
        chk("R9", "no ntf while busy", 64'(r_nv), 64'd0);
        while (busy_o && guard < 1000) begin
            @(negedge clk);
            guard++;
            if (busy_o) n++;
        end
        chk("R9", "busy cycle count", 64'(n), 64'(NUM_SRC));
        cmd(2'd0, 5, '0);
        chk("R8", "valid entry masked",
            r_rdata, mk(1'b1, 4'hA, 24'h123456, 1'b1, 31'h1234_5678));
        cmd(2'd0, 7, '0);
        chk("R8", "invalid entry unchanged",
            r_rdata, mk(1'b0, 4'h3, 24'h00_0777, 1'b0, 31'h7));
        cmd(2'd0, 9, '0);
        chk("R8", "free entry not masked", 64'(r_rdata[31]), 64'd0);
        trig(5);
        chk("R8", "masked by sweep no ntf", 64'(r_nv), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_route();
        t_invalid();
        t_masked();
        t_alloc_free();
        t_out_of_range();
        t_edges();
        t_collide();
        t_sweep();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule